// File: doc/BRIEF.md
# Multi-Operand Product Residue Modulo Eight

This block takes a set of unsigned operands and returns the three lowest bits of their full product, which is the product reduced modulo 8. It has no wide multiplier and no chain of multipliers. A priority search finds the first operand whose lowest bit is zero. For that operand, a one-bit right shift only renumbers its bits. Parity over single bit columns handles the case where every operand is odd.

The second result bit comes from one first-even search. The third result bit applies the second-bit logic again to each modified operand set, one set for each possible first-even position, and merges all the terms in a single OR. The nominal operand count `N_OPS` sets the width of this structure. When `N_USED` is smaller than `N_OPS`, the slots with no port behind them are filled with the value 1. Operand words must be at least 3 bits wide.

The logic ahead of the output is purely combinational. One output register captures the result while the input strobe is high. An asynchronous active-low reset clears the register.

Top module: `mp8_residue`

## Requirements
- R1: One cycle after a clock edge at which `in_valid` is high, `res_o` equals the product of all `N_USED` operands modulo 8.
- R2: Operand bits at position 3 and above have no effect on `res_o`.
- R3: `res_o[0]` is 1 exactly when every operand is odd.
- R4: The select vector of the first-even search has exactly one bit set. Bit i (i < N_OPS) marks slot i as the lowest-indexed even slot, and bit N_OPS marks that no slot is even.
- R5: For each of result bits 1 and 2, at most one input of the OR that forms the bit is high.
- R6: When all operands are odd, `res_o[1]` is the XOR of the operands' bit 1 and `res_o[2]` is the XOR of their bit 2.
- R7: Slots from `N_USED` to `N_OPS-1` act as operands of value 1, so they do not change the result.
- R8: An operand whose low three bits are 000 forces `res_o` to 000.
- R9: `res_valid_o` equals `in_valid` delayed by one clock. `res_o` loads only when `in_valid` is high and holds its value otherwise.
- R10: While `rst_n` is low, `res_o` is 000 and `res_valid_o` is 0, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set valid; enables the result register |
| in_ops | input | N_USED*OP_W | Operands; operand i occupies bits [i*OP_W +: OP_W] |
| res_o | output | 3 | Product modulo 8 |
| res_valid_o | output | 1 | `in_valid` delayed by one clock |

## Verification
The checker observes several properties on every clock. It confirms that the first-even select is one-hot and that each result-bit OR has at most one active input. It checks that the valid output follows the strobe and that the result holds when the strobe is low. It also checks that an even operand clears bit 0, that a zero operand clears the whole result, and that a change confined to the upper operand bits leaves the result unchanged. The arithmetic itself can only be shown by the bench's scenarios. These compare every result with an independently computed product modulo 8, over all-odd sets, an even operand at each slot, multiple even operands, zero operands, and a large set of random operands.

// File: rtl/mp8_pkg.sv
package mp8_pkg;
  localparam int RES_W = 3;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/mp8_first_even.sv
// Priority search: sel[i] marks the lowest-indexed even slot, sel[N] means all odd.
module mp8_first_even #(
  parameter int N = 8
) (
  input  logic [N-1:0] lsb,
  output logic [N:0]   sel
);
  logic run;

  always_comb begin
    run = 1'b1;
    for (int i = 0; i < N; i++) begin
      sel[i] = run & ~lsb[i];
      run    = run & lsb[i];
    end
    sel[N] = run;
  end
endmodule

// File: rtl/mp8_bit1.sv
// OR terms for bit 1 of a product, from the operand bit-0 and bit-1 columns.
module mp8_bit1 #(
  parameter int N = 8
) (
  input  logic [N-1:0] lsb,
  input  logic [N-1:0] b1,
  output logic [N:0]   terms
);
  logic [N:0]   sel;
  logic [N-1:0] others;

  mp8_first_even #(.N(N)) u_fe (
    .lsb (lsb),
    .sel (sel)
  );

  always_comb begin
    others = '0;
    for (int j = 0; j < N; j++) begin
      others    = lsb;
      others[j] = 1'b1;
      // slot j shifted right: its bit1 becomes bit0, every other slot must be odd
      terms[j]  = sel[j] & (&others) & b1[j];
    end
    terms[N] = sel[N] & (^b1);
  end
endmodule

// File: rtl/mp8_residue.sv
module mp8_residue
  import mp8_pkg::*;
#(
  parameter int N_OPS  = 8,
  parameter int N_USED = 6,
  parameter int OP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [N_USED*OP_W-1:0]   in_ops,
  output logic [RES_W-1:0]         res_o,
  output logic                     res_valid_o
);
  localparam int N = N_OPS;

  logic [N-1:0] col0, col1, col2;
  logic [N:0]   sel_top;
  logic [N:0]   b1_terms;
  logic [N:0]   b2_terms;
  res_t         res_d, res_q, res_n;
  logic         vld_q, vld_n;

  // column extraction with padding of unused slots to the value 1
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_col
      if (gi < N_USED) begin : g_live
        assign col0[gi] = in_ops[gi*OP_W + 0];
        assign col1[gi] = in_ops[gi*OP_W + 1];
        assign col2[gi] = in_ops[gi*OP_W + 2];
      end else begin : g_pad
        assign col0[gi] = 1'b1;
        assign col1[gi] = 1'b0;
        assign col2[gi] = 1'b0;
      end
    end
  endgenerate

  mp8_first_even #(.N(N)) u_fe_top (
    .lsb (col0),
    .sel (sel_top)
  );

  mp8_bit1 #(.N(N)) u_bit1 (
    .lsb   (col0),
    .b1    (col1),
    .terms (b1_terms)
  );

  // bit 2: for each first-even choice, bit 1 of the set with that slot shifted
  genvar gj;
  generate
    for (gj = 0; gj < N; gj++) begin : g_sub
      logic [N-1:0] lsb_m, b1_m;
      logic [N:0]   sub_terms;
      always_comb begin
        lsb_m     = col0;
        b1_m      = col1;
        lsb_m[gj] = col1[gj];
        b1_m[gj]  = col2[gj];
      end
      mp8_bit1 #(.N(N)) u_sub (
        .lsb   (lsb_m),
        .b1    (b1_m),
        .terms (sub_terms)
      );
      assign b2_terms[gj] = sel_top[gj] & (|sub_terms);
    end
  endgenerate
  assign b2_terms[N] = sel_top[N] & (^col2);

  assign res_d = {|b2_terms, |b1_terms, &col0};

  // next state
  always_comb begin
    res_n = res_q;
    if (in_valid) res_n = res_d;
    vld_n = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_n;
      vld_q <= vld_n;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = vld_q;
endmodule

// File: rtl/mp8_residue_chk.sv
module mp8_residue_chk #(
  parameter int N_OPS  = 8,
  parameter int N_USED = 6,
  parameter int OP_W   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [N_USED*OP_W-1:0] in_ops,
  input logic [N_OPS:0]         sel_top,
  input logic [N_OPS:0]         b1_terms,
  input logic [N_OPS:0]         b2_terms,
  input logic [2:0]             res_o,
  input logic                   res_valid_o
);
  logic [3*N_USED-1:0] low3;
  logic [N_USED*OP_W-1:0] hi_only;
  logic zero_any;

  always_comb begin
    zero_any = 1'b0;
    hi_only  = in_ops;
    for (int i = 0; i < N_USED; i++) begin
      low3[i*3 +: 3] = in_ops[i*OP_W +: 3];
      hi_only[i*OP_W +: 3] = 3'b000;
      if (in_ops[i*OP_W +: 3] == 3'b000) zero_any = 1'b1;
    end
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_top) == 1);
  // R5
  or1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(b1_terms));
  // R5
  or2_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(b2_terms));
  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid_o);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_o));
  // R3
  even_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_top[N_OPS]) |=> (res_o[0] == 1'b0));
  // R8
  zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_any) |=> (res_o == 3'b000));
  // R2
  upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && low3 == $past(low3) && hi_only != $past(hi_only))
      |=> $stable(res_o));
endmodule

bind mp8_residue mp8_residue_chk #(.N_OPS(N_OPS), .N_USED(N_USED), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ops      (in_ops),
  .sel_top     (sel_top),
  .b1_terms    (b1_terms),
  .b2_terms    (b2_terms),
  .res_o       (res_o),
  .res_valid_o (res_valid_o)
);

// File: tb/mp8_residue_tb.sv
module mp8_residue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_OPS  = 8;
  localparam int N_USED = 6;
  localparam int OP_W   = 8;
  localparam int VW     = N_USED*OP_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] in_ops;
  logic [2:0]    res_o;
  logic          res_valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp8_residue #(.N_OPS(N_OPS), .N_USED(N_USED), .OP_W(OP_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ops (in_ops),
    .res_o (res_o), .res_valid_o (res_valid_o)
  );

  function automatic int ref_mod8(input logic [VW-1:0] ops);
    longint p = 1;
    for (int i = 0; i < N_USED; i++) p = (p * longint'(ops[i*OP_W +: OP_W])) % 8;
    return int'(p);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample at the next falling edge
  task automatic apply(input logic [VW-1:0] ops, input string req);
    int e;
    in_ops = ops;
    in_valid = 1'b1;
    e = ref_mod8(ops);
    @(negedge clk);
    check(int'(res_o) == e, req, int'(res_o), e);
    check(res_valid_o == 1'b1, {req, " R9 valid"}, int'(res_valid_o), 1);
  endtask

  function automatic logic [VW-1:0] fill(input int v);
    logic [VW-1:0] o;
    for (int i = 0; i < N_USED; i++) o[i*OP_W +: OP_W] = OP_W'(v);
    return o;
  endfunction

  function automatic logic [VW-1:0] rnd_ops(input bit odd);
    logic [VW-1:0] o;
    for (int i = 0; i < N_USED; i++) begin
      o[i*OP_W +: OP_W] = OP_W'($urandom);
      if (odd) o[i*OP_W] = 1'b1;
    end
    return o;
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] o, o2;
    logic [2:0] held;
    int x1, x2;
    rst_n = 1'b0; in_valid = 1'b0; in_ops = '0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check(res_o == 3'b000, "R10 res in reset", int'(res_o), 0);
    check(res_valid_o == 1'b0, "R10 valid in reset", int'(res_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 all odd: all ones, then random odd sets with column XORs
    apply(fill(1), "R6 all ones");
    for (int k = 0; k < 20; k++) begin
      o = rnd_ops(1'b1);
      x1 = 0; x2 = 0;
      for (int i = 0; i < N_USED; i++) begin
        x1 ^= int'(o[i*OP_W+1]); x2 ^= int'(o[i*OP_W+2]);
      end
      apply(o, "R6 odd set");
      check(int'(res_o[1]) == x1, "R6 bit1 xor", int'(res_o[1]), x1);
      check(int'(res_o[2]) == x2, "R6 bit2 xor", int'(res_o[2]), x2);
      check(res_o[0] == 1'b1, "R3 odd bit0", int'(res_o[0]), 1);
    end

    // R1 an even operand at each slot, values 2, 4, 6
    for (int j = 0; j < N_USED; j++)
      for (int v = 2; v <= 6; v += 2) begin
        o = fill(3);
        o[j*OP_W +: OP_W] = OP_W'(v);
        apply(o, "R1 single even");
        check(res_o[0] == 1'b0, "R3 even bit0", int'(res_o[0]), 0);
      end
    // R1 two and three even operands
    o = fill(5); o[0 +: OP_W] = 8'd6; o[3*OP_W +: OP_W] = 8'd2;
    apply(o, "R1 two even");
    o = fill(7); o[1*OP_W +: OP_W] = 8'd2; o[2*OP_W +: OP_W] = 8'd2; o[4*OP_W +: OP_W] = 8'd2;
    apply(o, "R1 three even");

    // R8 zero low bits
    o = fill(7); o[2*OP_W +: OP_W] = 8'd0;
    apply(o, "R8 zero operand");
    o = fill(3); o[5*OP_W +: OP_W] = 8'd8;
    apply(o, "R8 low bits zero");

    // R7 padding: 7^6 mod 8 = 1, 3^6 mod 8 = 1, 5*... via reference
    apply(fill(7), "R7 padded all seven");
    apply(fill(6), "R7 padded all six");

    // R2 upper bits changed, low bits kept
    for (int k = 0; k < 10; k++) begin
      o = rnd_ops(1'b0);
      apply(o, "R2 base");
      o2 = rnd_ops(1'b0);
      for (int i = 0; i < N_USED; i++) o2[i*OP_W +: 3] = o[i*OP_W +: 3];
      held = res_o;
      apply(o2, "R2 upper changed");
      check(res_o == held, "R2 result unchanged", int'(res_o), int'(held));
    end

    // R9 strobe low: result holds, valid falls
    held = res_o;
    in_valid = 1'b0; in_ops = fill(2);
    @(negedge clk);
    check(res_valid_o == 1'b0, "R9 valid low", int'(res_valid_o), 0);
    check(res_o == held, "R9 result held", int'(res_o), int'(held));

    // R1 random sets
    for (int k = 0; k < 500; k++) apply(rnd_ops(1'b0), "R1 random");

    // R10 asynchronous reset mid-run
    apply(fill(3), "R1 before reset");
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check(res_o == 3'b000, "R10 async clear res", int'(res_o), 0);
    check(res_valid_o == 1'b0, "R10 async clear valid", int'(res_valid_o), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(fill(5), "R1 after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule